// File: doc/BRIEF.md
# Power-Up Strap Latch and Clock-Rate Decoder

This block takes the board's configuration straps for a clock generator, three rate-select straps and one strap that chooses what the shared differential output pair carries, and captures them exactly once after reset. The capture happens on the first moment the active-low power-good input reports that the straps have settled. From then on the captured values are frozen until the next reset, so later glitches on the strap pins or on power-good cannot change the clock configuration while the clock tree is running.

The frozen three-bit rate code is decoded into an enumerated CPU-rate index and a whole-number MHz value for the downstream divider logic. The fixed rates of the SRC, PCI and DOT trees are also provided. A status byte carries the captured straps for register-file readback, and a valid flag tells consumers when the captured values are meaningful. Every strap and power-good input passes through a two-flop synchronizer before it is used.

Top module: `boot_strap_latch`

## Requirements
- R1: While reset is held and after its release before any capture, straps_valid_o is 0, code_o is 3'b001 (floating-pin levels: bit0 pulled high, bits 1 and 2 pulled low), pair_is_cpu_o is 0, and status_o is 8'h01.
- R2: When pwr_ok_n_i falls (between clock edges) after reset, the straps are captured on the third rising clock edge after the fall. On that edge straps_valid_o rises and code_o takes the sel_strap_i value that was held stable across the fall.
- R3: After the capture, code_o and pair_is_cpu_o do not change until the next reset. This holds when the straps change and when pwr_ok_n_i rises and falls again.
- R4: While pwr_ok_n_i stays high, no capture occurs. straps_valid_o stays 0 and code_o keeps its reset value, whatever the straps do.
- R5: cpu_idx_o decodes code_o into a rate index, ordered by rising frequency: 0=100, 1=133.33, 2=166.66, 3=200, 4=266.66, 5=333.33, 6=400 MHz. The mapping is code 000->4, 001->1, 010->3, 011->2, 100->5, 101->0, 110->6, 111->3.
- R6: cpu_mhz_o gives the truncated whole-MHz CPU rate for code_o: 266, 133, 200, 166, 333, 100, 400, 200 for codes 000 through 111.
- R7: src_mhz_o is 100, pci_mhz_o is 33 and dot_mhz_o is 96 for every code, before and after capture.
- R8: pair_is_cpu_o takes the captured level of pair_strap_i: 1 routes a CPU clock to the shared pair, 0 routes the eighth SRC clock.
- R9: status_o[2:0] equals code_o (bit n is rate strap n), status_o[3] equals pair_is_cpu_o, and status_o[7:4] are 0.
- R10: Once high, straps_valid_o stays high until reset. Asserting and releasing rst_n re-arms the latch, so that a later power-good fall captures new strap values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_strap_i | input | 3 | Rate-select strap levels, bit n = strap n |
| pair_strap_i | input | 1 | Shared-pair select strap level |
| pwr_ok_n_i | input | 1 | Active-low power-good; a fall marks the straps valid |
| code_o | output | 3 | Captured rate-select code |
| cpu_idx_o | output | 3 | Enumerated CPU rate index |
| cpu_mhz_o | output | 9 | CPU rate in whole MHz |
| src_mhz_o | output | 9 | SRC tree rate, fixed |
| pci_mhz_o | output | 9 | PCI tree rate, fixed |
| dot_mhz_o | output | 9 | DOT tree rate, fixed |
| pair_is_cpu_o | output | 1 | 1: shared pair carries CPU clock |
| status_o | output | 8 | Readback byte of captured straps |
| straps_valid_o | output | 1 | Captured values valid |

## Verification
The bench builds the block with its default parameters: three rate straps, two synchronizer stages and nine-bit MHz fields. With these values the whole eight-entry code space is reached, and each code is captured after its own reset. The fixed synchronizer depth puts the capture on a known edge, so the bench can check the valid flag just before that edge and just after it. It also checks that the latch is frozen, by toggling the straps and power-good after capture and with power-good held inactive.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int SEL_W = 3;
  localparam int MHZ_W = 9;
  localparam int SRC_RATE = 100;
  localparam int PCI_RATE = 33;
  localparam int DOT_RATE = 96;
  localparam logic [SEL_W-1:0] SEL_FLOAT = 3'b001;

  typedef enum logic [2:0] {
    RATE_100 = 3'd0,
    RATE_133 = 3'd1,
    RATE_166 = 3'd2,
    RATE_200 = 3'd3,
    RATE_266 = 3'd4,
    RATE_333 = 3'd5,
    RATE_400 = 3'd6
  } cpu_rate_e;

  function automatic cpu_rate_e code_to_rate(input logic [SEL_W-1:0] c);
    case (c)
      3'b000:  return RATE_266;
      3'b001:  return RATE_133;
      3'b010:  return RATE_200;
      3'b011:  return RATE_166;
      3'b100:  return RATE_333;
      3'b101:  return RATE_100;
      3'b110:  return RATE_400;
      default: return RATE_200;
    endcase
  endfunction

  function automatic logic [MHZ_W-1:0] rate_to_mhz(input cpu_rate_e r);
    case (r)
      RATE_100: return MHZ_W'(100);
      RATE_133: return MHZ_W'(133);
      RATE_166: return MHZ_W'(166);
      RATE_200: return MHZ_W'(200);
      RATE_266: return MHZ_W'(266);
      RATE_333: return MHZ_W'(333);
      default:  return MHZ_W'(400);
    endcase
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= INIT;
    end else begin
      chain[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_sync_i,
  input  logic             pair_sync_i,
  input  logic             pg_n_sync_i,
  output logic [SEL_W-1:0] code_o,
  output logic             pair_o,
  output logic             valid_o,
  output logic             cap_evt_o
);
  logic pg_n_prev;

  assign cap_evt_o = !valid_o && pg_n_prev && !pg_n_sync_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pg_n_prev <= 1'b1;
      code_o    <= SEL_FLOAT;
      pair_o    <= 1'b0;
      valid_o   <= 1'b0;
    end else begin
      pg_n_prev <= pg_n_sync_i;
      if (cap_evt_o) begin
        code_o  <= sel_sync_i;
        pair_o  <= pair_sync_i;
        valid_o <= 1'b1;
      end
    end
  end

  // R10
  valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);
  // R3
  code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> ($stable(code_o) && $stable(pair_o)));
  // R4
  no_early_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && !cap_evt_o) |=> (!valid_o && code_o == SEL_FLOAT));
  // R2
  capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt_o |=> (valid_o && code_o == $past(sel_sync_i) && pair_o == $past(pair_sync_i)));
endmodule

// File: rtl/rate_decoder.sv
module rate_decoder
  import strap_pkg::*;
(
  input  logic [SEL_W-1:0] code_i,
  output logic [2:0]       idx_o,
  output logic [MHZ_W-1:0] cpu_mhz_o,
  output logic [MHZ_W-1:0] src_mhz_o,
  output logic [MHZ_W-1:0] pci_mhz_o,
  output logic [MHZ_W-1:0] dot_mhz_o
);
  cpu_rate_e rate;

  always_comb begin
    rate      = code_to_rate(code_i);
    idx_o     = rate;
    cpu_mhz_o = rate_to_mhz(rate);
  end

  assign src_mhz_o = MHZ_W'(SRC_RATE);
  assign pci_mhz_o = MHZ_W'(PCI_RATE);
  assign dot_mhz_o = MHZ_W'(DOT_RATE);
endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import strap_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel_strap_i,
  input  logic             pair_strap_i,
  input  logic             pwr_ok_n_i,
  output logic [SEL_W-1:0] code_o,
  output logic [2:0]       cpu_idx_o,
  output logic [MHZ_W-1:0] cpu_mhz_o,
  output logic [MHZ_W-1:0] src_mhz_o,
  output logic [MHZ_W-1:0] pci_mhz_o,
  output logic [MHZ_W-1:0] dot_mhz_o,
  output logic             pair_is_cpu_o,
  output logic [7:0]       status_o,
  output logic             straps_valid_o
);
  localparam int IN_W = SEL_W + 2;
  localparam logic [IN_W-1:0] IN_INIT = {1'b1, 1'b0, SEL_FLOAT};

  logic [IN_W-1:0] raw_in, sync_out;
  logic [SEL_W-1:0] sel_sync;
  logic pair_sync, pg_n_sync, cap_evt;

  assign raw_in = {pwr_ok_n_i, pair_strap_i, sel_strap_i};

  strap_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .INIT(IN_INIT)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  assign sel_sync  = sync_out[SEL_W-1:0];
  assign pair_sync = sync_out[SEL_W];
  assign pg_n_sync = sync_out[SEL_W+1];

  strap_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .sel_sync_i(sel_sync), .pair_sync_i(pair_sync), .pg_n_sync_i(pg_n_sync),
    .code_o(code_o), .pair_o(pair_is_cpu_o), .valid_o(straps_valid_o),
    .cap_evt_o(cap_evt)
  );

  rate_decoder u_dec (
    .code_i(code_o), .idx_o(cpu_idx_o), .cpu_mhz_o(cpu_mhz_o),
    .src_mhz_o(src_mhz_o), .pci_mhz_o(pci_mhz_o), .dot_mhz_o(dot_mhz_o)
  );

  assign status_o = {4'b0000, pair_is_cpu_o, code_o};

  // R9
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    straps_valid_o |-> (status_o[2:0] == code_o && status_o[3] == pair_is_cpu_o));
  // R2
  capture_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(straps_valid_o) |-> $past(cap_evt));
endmodule

// File: tb/tb_boot_strap_latch.sv
module tb_boot_strap_latch;
  logic clk = 0;
  logic rst_n = 0;
  logic [2:0] sel_strap_i = 3'b001;
  logic pair_strap_i = 0;
  logic pwr_ok_n_i = 1;
  logic [2:0] code_o, cpu_idx_o;
  logic [8:0] cpu_mhz_o, src_mhz_o, pci_mhz_o, dot_mhz_o;
  logic pair_is_cpu_o, straps_valid_o;
  logic [7:0] status_o;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  boot_strap_latch dut (.*);

  function automatic int mhz_of(input logic [2:0] c);
    int tbl [8] = '{266, 133, 200, 166, 333, 100, 400, 200};
    return tbl[c];
  endfunction

  function automatic int idx_of(input int mhz);
    int order [7] = '{100, 133, 166, 200, 266, 333, 400};
    for (int k = 0; k < 7; k++) if (order[k] == mhz) return k;
    return -1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    pwr_ok_n_i = 1;
    edges(2);
    rst_n = 1;
    edges(2);
  endtask

  task automatic t_reset_state();
    sel_strap_i = 3'b110; pair_strap_i = 1;
    do_reset();
    chk("R1 valid", straps_valid_o, 0);
    chk("R1 code", code_o, 1);
    chk("R1 pair", pair_is_cpu_o, 0);
    chk("R1 status", status_o, 8'h01);
    chk("R7 src pre", src_mhz_o, 100);
  endtask

  task automatic t_capture(input logic [2:0] c, input logic p);
    do_reset();
    sel_strap_i = c; pair_strap_i = p;
    edges(4);
    pwr_ok_n_i = 0;
    edges(2);
    chk("R2 not yet valid", straps_valid_o, 0);
    edges(1);
    chk("R2 valid on third edge", straps_valid_o, 1);
    chk("R2 code", code_o, c);
    chk("R6 cpu mhz", cpu_mhz_o, mhz_of(c));
    chk("R5 cpu idx", cpu_idx_o, idx_of(mhz_of(c)));
    chk("R7 src", src_mhz_o, 100);
    chk("R7 pci", pci_mhz_o, 33);
    chk("R7 dot", dot_mhz_o, 96);
    chk("R8 pair", pair_is_cpu_o, p);
    chk("R9 status", status_o, {4'b0, p, c});
  endtask

  task automatic t_refreeze();
    t_capture(3'b011, 0);
    sel_strap_i = 3'b100; pair_strap_i = 1;
    edges(4);
    pwr_ok_n_i = 1;
    edges(5);
    pwr_ok_n_i = 0;
    edges(6);
    chk("R3 code frozen", code_o, 3'b011);
    chk("R3 pair frozen", pair_is_cpu_o, 0);
    chk("R10 valid held", straps_valid_o, 1);
  endtask

  task automatic t_no_pgood();
    do_reset();
    for (int k = 0; k < 8; k++) begin
      sel_strap_i = 3'(k); pair_strap_i = k[0];
      edges(3);
    end
    chk("R4 valid low", straps_valid_o, 0);
    chk("R4 code default", code_o, 1);
    chk("R4 status default", status_o, 8'h01);
  endtask

  task automatic t_rearm();
    t_capture(3'b101, 1);
    t_capture(3'b010, 0);
    chk("R10 rearm code", code_o, 3'b010);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    for (int c = 0; c < 8; c++) t_capture(3'(c), c[1]);
    t_capture(3'b001, 0);
    t_refreeze();
    t_no_pgood();
    t_rearm();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule